// File: doc/BRIEF.md
# Write-Only I2C Configuration Target

This block is an I2C target that only accepts writes. It answers one fixed 7-bit address and stores the bytes it receives in an 8-entry bank of 8-bit registers. Each register drives a decoded field of a waveform-generator configuration. The SCL and SDA inputs are oversampled by the system clock, so a fast core clock has to watch a slow bus. The target acknowledges by pulling SDA low through a single registered pull-down output.

A transfer starts with a START, followed by the address byte and then a register pointer byte. Any number of data bytes may follow. Each data byte goes to the register under the pointer, and the pointer then steps up by one. Register 0 is special. Its top bit is a motion direction, and its low seven bits are a move count. Each write adds the count to a pending total, and that total stops at a cap. Every write to register 0 also raises a one-cycle strobe for the drive engine. A test input, sampled while reset is held, loads fixed timing presets. While that input stays high, the preset registers cannot be overwritten from the bus.

Top module: `i2c_wr_slave`

## Requirements
- R1: An address byte of 0xE4 (address 1110010 followed by a 0 write bit, MSB first) is acknowledged: `sda_pull` is high during the ninth SCL pulse.
- R2: Any other address byte, including 0xE5 (read), gets no acknowledge. Every later byte up to the next START is then ignored: no acknowledge and no register change.
- R3: The byte after the address sets the register pointer. Each later data byte is written to the register under the pointer, and the pointer then increments (it holds at 255).
- R4: A data byte whose pointer is 8 or above is acknowledged and then discarded.
- R5: A write to register 0 sets `op_dir` from bit 7 and adds bits 6:0 to `op_pending`. The sum saturates at 512.
- R6: When the bit-7 value of a register 0 write differs from `op_dir`, the pending total is cleared before the new count is added.
- R7: Each register 0 write produces exactly one single-cycle pulse on `op_strobe`.
- R8: Register 1 decodes as `gate_mode` = bit 7, `clk_sel` = bits 4:3, `init_off` = bit 2 and `swing_back` = bits 1:0.
- R9: Registers 2 to 6 drive `period`, `gate_a_set`, `gate_b_clr`, `gate_b_set` and `step_count`. Register 7 bits 3:0 drive `init_move`. Reset clears every register, `op_dir`, `op_pending` and `sda_pull`.
- R10: A reset with `test_preset` high loads registers 2 to 7 with 115, 21, 24, 54, 139 and 10. While `test_preset` stays high, bus writes to registers 2 to 7 have no effect. Registers 0 and 1 stay writable.
- R11: A repeated START restarts the address phase. After a STOP, bytes clocked without a new START are ignored.
- R12: `sda_pull` changes only while the synchronized SCL is low. It is released by the end of the acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| test_preset | input | 1 | Loads timing presets at reset and locks registers 2 to 7 |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line (wired level) |
| sda_pull | output | 1 | Drive SDA low when high (acknowledge) |
| op_dir | output | 1 | Motion direction from register 0 |
| op_pending | output | 10 | Accumulated move count, 0 to 512 |
| op_strobe | output | 1 | One-cycle pulse per register 0 write |
| gate_mode | output | 1 | Gate output mode select |
| clk_sel | output | 2 | Reference clock divider select |
| init_off | output | 1 | Start-up sequence disable |
| swing_back | output | 2 | Start-up swing-back count code |
| period | output | 8 | Waveform period count |
| gate_a_set | output | 8 | Gate A edge count |
| gate_b_clr | output | 8 | Gate B first edge count |
| gate_b_set | output | 8 | Gate B second edge count |
| step_count | output | 8 | Steps per drive unit |
| init_move | output | 4 | Start-up move count code |

## Verification
Two things can happen on the same clock edge in the register 0 path: the pending total is cleared by a direction change, and the new count is added to it. The bench writes counts with a flipped direction bit right after the total has built up, sometimes up to the 512 cap. It expects the pending output to equal exactly the new count, with one strobe pulse. A second collision is the test lock meeting a bus write on the same register. Here the write is acknowledged, and the bench expects the preset value to remain and a neighbouring unlocked register to update.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {LK_IDLE, LK_BITS, LK_ACK, LK_SKIP} link_state_e;
  typedef enum logic [1:0] {BP_ADDR, BP_PTR, BP_DATA} byte_phase_e;

  // Timing presets applied when the test input is high during reset.
  function automatic logic [BYTE_W-1:0] preset_value(input int idx);
    case (idx)
      2: return 8'd115;
      3: return 8'd21;
      4: return 8'd24;
      5: return 8'd54;
      6: return 8'd139;
      7: return 8'd10;
      default: return '0;
    endcase
  endfunction

  // Registers at or above this index are locked by the test input.
  localparam int LOCK_FIRST = 2;
endpackage

// File: rtl/i2c_wr_sync.sv
module i2c_wr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_prev
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) dout_prev <= '1;
    else     dout_prev <= dout;
  end
endmodule

// File: rtl/i2c_wr_link.sv
module i2c_wr_link
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1110010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic              scl_prev,
  input  logic              sda_prev,
  output logic              sda_pull,
  output logic              wr_valid,
  output logic              wr_is_ptr,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  link_state_e       state;
  byte_phase_e       phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl & ~scl_prev;
  assign scl_fall = ~scl & scl_prev;
  assign start_ev = scl & scl_prev & sda_prev & ~sda;
  assign stop_ev  = scl & scl_prev & ~sda_prev & sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LK_IDLE;
      phase     <= BP_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      sda_pull  <= 1'b0;
      wr_valid  <= 1'b0;
      wr_is_ptr <= 1'b0;
      wr_byte   <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_ev) begin
        state    <= LK_BITS;
        phase    <= BP_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= LK_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          LK_BITS: begin
            if (scl_rise && bitcnt != FULL) begin
              shreg  <= {shreg[BYTE_W-2:0], sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              if (phase == BP_ADDR && shreg != {DEV_ADDR, 1'b0}) begin
                state <= LK_SKIP;
              end else begin
                sda_pull <= 1'b1;
                state    <= LK_ACK;
                if (phase != BP_ADDR) begin
                  wr_valid  <= 1'b1;
                  wr_is_ptr <= (phase == BP_PTR);
                  wr_byte   <= shreg;
                end
              end
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              state    <= LK_BITS;
              phase    <= (phase == BP_ADDR) ? BP_PTR : BP_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wr_regfile.sv
module i2c_wr_regfile
  import i2c_wr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int PEND_CAP = 512,
  parameter int PEND_W   = $clog2(PEND_CAP + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           test_preset,
  input  logic                           wr_valid,
  input  logic                           wr_is_ptr,
  input  logic [BYTE_W-1:0]              wr_byte,
  output logic                           dir_q,
  output logic [PEND_W-1:0]              pend_q,
  output logic                           strobe_q,
  output logic [NUM_REGS-1:0][BYTE_W-1:0] cfg_q
);
  localparam int SUM_W = PEND_W + 1;
  localparam logic [SUM_W-1:0] CAP = SUM_W'(PEND_CAP);

  logic [BYTE_W-1:0] ptr;
  logic              data_wr;
  assign data_wr = wr_valid & ~wr_is_ptr;

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (wr_valid) begin
      if (wr_is_ptr)       ptr <= wr_byte;
      else if (ptr != '1)  ptr <= ptr + 1'b1;
    end
  end

  // Register 0: direction plus saturating pending count.
  logic              hit0;
  logic [PEND_W-1:0] base;
  logic [SUM_W-1:0]  sum;
  assign hit0 = data_wr && (ptr == '0);
  assign base = (wr_byte[BYTE_W-1] != dir_q) ? '0 : pend_q;
  assign sum  = {1'b0, base} + {{(SUM_W-BYTE_W+1){1'b0}}, wr_byte[BYTE_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= 1'b0;
      pend_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= hit0;
      if (hit0) begin
        dir_q  <= wr_byte[BYTE_W-1];
        pend_q <= (sum > CAP) ? PEND_W'(PEND_CAP) : sum[PEND_W-1:0];
      end
    end
  end

  assign cfg_q[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    logic              locked;
    assign locked = test_preset && (i >= LOCK_FIRST);
    always_ff @(posedge clk) begin
      if (rst)
        q <= test_preset ? preset_value(i) : '0;
      else if (data_wr && ptr == BYTE_W'(i) && !locked)
        q <= wr_byte;
    end
    assign cfg_q[i] = q;
  end
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1110010,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 8,
  parameter int         PEND_CAP    = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       test_preset,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       op_dir,
  output logic [9:0] op_pending,
  output logic       op_strobe,
  output logic       gate_mode,
  output logic [1:0] clk_sel,
  output logic       init_off,
  output logic [1:0] swing_back,
  output logic [7:0] period,
  output logic [7:0] gate_a_set,
  output logic [7:0] gate_b_clr,
  output logic [7:0] gate_b_set,
  output logic [7:0] step_count,
  output logic [3:0] init_move
);
  localparam int PEND_W = $clog2(PEND_CAP + 1);

  logic scl_s, sda_s, scl_p, sda_p;
  logic              wr_valid, wr_is_ptr;
  logic [BYTE_W-1:0] wr_byte;
  logic [NUM_REGS-1:0][BYTE_W-1:0] cfg;
  logic [PEND_W-1:0] pend;

  i2c_wr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .din({scl_in, sda_in}),
    .dout({scl_s, sda_s}), .dout_prev({scl_p, sda_p})
  );

  i2c_wr_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s),
    .scl_prev(scl_p), .sda_prev(sda_p), .sda_pull(sda_pull),
    .wr_valid(wr_valid), .wr_is_ptr(wr_is_ptr), .wr_byte(wr_byte)
  );

  i2c_wr_regfile #(.NUM_REGS(NUM_REGS), .PEND_CAP(PEND_CAP), .PEND_W(PEND_W)) u_regs (
    .clk(clk), .rst(rst), .test_preset(test_preset),
    .wr_valid(wr_valid), .wr_is_ptr(wr_is_ptr), .wr_byte(wr_byte),
    .dir_q(op_dir), .pend_q(pend), .strobe_q(op_strobe), .cfg_q(cfg)
  );

  assign op_pending = 10'(pend);
  assign gate_mode  = cfg[1][7];
  assign clk_sel    = cfg[1][4:3];
  assign init_off   = cfg[1][2];
  assign swing_back = cfg[1][1:0];
  assign period     = cfg[2];
  assign gate_a_set = cfg[3];
  assign gate_b_clr = cfg[4];
  assign gate_b_set = cfg[5];
  assign step_count = cfg[6];
  assign init_move  = cfg[7][3:0];
endmodule

// File: rtl/i2c_wr_checker.sv
module i2c_wr_checker #(
  parameter int PEND_CAP = 512
) (
  input logic       clk,
  input logic       rst,
  input logic       test_preset,
  input logic       scl_s,
  input logic       sda_pull,
  input logic       op_dir,
  input logic [9:0] op_pending,
  input logic       op_strobe,
  input logic [7:0] period,
  input logic [7:0] step_count
);
  p_cap_r5: assert property (@(posedge clk) disable iff (rst)
    op_pending <= 10'(PEND_CAP));

  p_accum_r5: assert property (@(posedge clk) disable iff (rst)
    op_strobe && $stable(op_dir) |-> op_pending >= $past(op_pending));

  p_dir_clear_r6: assert property (@(posedge clk) disable iff (rst)
    op_strobe && !$stable(op_dir) |-> op_pending <= 10'd127);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    op_strobe |=> !op_strobe);

  p_pull_on_low_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_s);

  p_test_lock_r10: assert property (@(posedge clk) disable iff (rst)
    test_preset |=> $stable(period) && $stable(step_count));
endmodule

bind i2c_wr_slave i2c_wr_checker u_chk (
  .clk(clk), .rst(rst), .test_preset(test_preset), .scl_s(scl_s),
  .sda_pull(sda_pull), .op_dir(op_dir), .op_pending(op_pending),
  .op_strobe(op_strobe), .period(period), .step_count(step_count)
);

// File: tb/i2c_wr_slave_bench.sv
module i2c_wr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_preset = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic sda_pull, op_dir, op_strobe, gate_mode, init_off;
  logic [9:0] op_pending;
  logic [1:0] clk_sel, swing_back;
  logic [7:0] period, gate_a_set, gate_b_clr, gate_b_set, step_count;
  logic [3:0] init_move;

  assign sda_line = sda_drv & ~sda_pull;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_wr_slave u_i2c_wr_slave (
    .clk(clk), .rst(rst), .test_preset(test_preset), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .op_dir(op_dir), .op_pending(op_pending), .op_strobe(op_strobe),
    .gate_mode(gate_mode), .clk_sel(clk_sel), .init_off(init_off), .swing_back(swing_back),
    .period(period), .gate_a_set(gate_a_set), .gate_b_clr(gate_b_clr),
    .gate_b_set(gate_b_set), .step_count(step_count), .init_move(init_move)
  );

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  bit done = 1'b0;
  bit last_rel;

  logic [7:0] m_cfg [8];
  logic       m_dir;
  int         m_pend;
  bit         m_lock;

  always @(posedge clk) if (!rst && op_strobe) strobes++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(1); scl = 1'b1; wq(1); sda_drv = 1'b0; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(1); scl = 1'b1; wq(1); sda_drv = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1);
    end
    sda_drv = 1'b1; wq(1); scl = 1'b1; wq(1);
    ack = (sda_line == 1'b0);
    wq(1); scl = 1'b0; wq(1);
    last_rel = (sda_pull == 1'b0);
  endtask

  task automatic model_write(input int p, input logic [7:0] d);
    if (p == 0) begin
      if (d[7] != m_dir) m_pend = 0;
      m_dir = d[7];
      m_pend = m_pend + int'(d[6:0]);
      if (m_pend > 512) m_pend = 512;
    end else if (p < 8 && !(m_lock && p >= 2)) begin
      m_cfg[p] = d;
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(op_dir == m_dir, {tag, " dir"}, int'(op_dir), int'(m_dir));
    chk(int'(op_pending) == m_pend, {tag, " pending"}, int'(op_pending), m_pend);
    chk(gate_mode == m_cfg[1][7], {tag, " R8 gate_mode"}, int'(gate_mode), int'(m_cfg[1][7]));
    chk(clk_sel == m_cfg[1][4:3], {tag, " R8 clk_sel"}, int'(clk_sel), int'(m_cfg[1][4:3]));
    chk(init_off == m_cfg[1][2], {tag, " R8 init_off"}, int'(init_off), int'(m_cfg[1][2]));
    chk(swing_back == m_cfg[1][1:0], {tag, " R8 swing_back"}, int'(swing_back), int'(m_cfg[1][1:0]));
    chk(period == m_cfg[2], {tag, " R9 period"}, int'(period), int'(m_cfg[2]));
    chk(gate_a_set == m_cfg[3], {tag, " R9 gate_a_set"}, int'(gate_a_set), int'(m_cfg[3]));
    chk(gate_b_clr == m_cfg[4], {tag, " R9 gate_b_clr"}, int'(gate_b_clr), int'(m_cfg[4]));
    chk(gate_b_set == m_cfg[5], {tag, " R9 gate_b_set"}, int'(gate_b_set), int'(m_cfg[5]));
    chk(step_count == m_cfg[6], {tag, " R9 step_count"}, int'(step_count), int'(m_cfg[6]));
    chk(init_move == m_cfg[7][3:0], {tag, " R9 init_move"}, int'(init_move), int'(m_cfg[7][3:0]));
  endtask

  // Burst write: pointer then n data bytes; acks are checked, model follows R3.
  task automatic burst(input int p, input int n, input logic [7:0] seed, input string tag);
    bit ack;
    int ptr = p;
    bus_start();
    send_byte(8'hE4, ack); chk(ack, {tag, " R1 addr ack"}, int'(ack), 1);
    send_byte(8'(p), ack); chk(ack, {tag, " R3 ptr ack"}, int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed + 8'(k * 29);
      send_byte(d, ack); chk(ack, {tag, " R4 data ack"}, int'(ack), 1);
      model_write(ptr, d);
      if (ptr < 255) ptr++;
    end
    bus_stop();
  endtask

  task automatic do_reset(input bit tp);
    test_preset = tp;
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; @(negedge clk);
    for (int i = 0; i < 8; i++) m_cfg[i] = 8'h00;
    m_dir = 1'b0; m_pend = 0; m_lock = tp;
    if (tp) begin
      m_cfg[2] = 8'd115; m_cfg[3] = 8'd21; m_cfg[4] = 8'd24;
      m_cfg[5] = 8'd54;  m_cfg[6] = 8'd139; m_cfg[7] = 8'd10;
    end
  endtask

  initial begin
    bit ack;
    int s0;
    logic [7:0] reg0_seq [10];
    do_reset(1'b0);
    chk(sda_pull == 1'b0, "R9 reset pull", int'(sda_pull), 0);
    chk(op_strobe == 1'b0, "R9 reset strobe", int'(op_strobe), 0);
    cmp_all("R9 reset");

    // R1 / R2: sweep every 7-bit address with the write bit.
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      bus_stop();
      if (a == 7'h72) chk(ack == 1'b1, "R1 addr sweep", int'(ack), 1);
      else            chk(ack == 1'b0, "R2 addr sweep", int'(ack), 0);
    end
    bus_start(); send_byte(8'hE5, ack); bus_stop();
    chk(ack == 1'b0, "R2 read bit", int'(ack), 0);

    // R2: mismatched transfer ignored up to next START.
    bus_start(); send_byte(8'hE5, ack);
    send_byte(8'h02, ack); chk(ack == 1'b0, "R2 skip ptr", int'(ack), 0);
    send_byte(8'h77, ack); chk(ack == 1'b0, "R2 skip data", int'(ack), 0);
    bus_stop();
    cmp_all("R2 skip");

    // R3 / R8 / R9: single writes to every register 1..7.
    for (int p = 1; p < 8; p++) begin
      burst(p, 1, 8'((p * 53 + 17) & 255), "R3 single");
      chk(last_rel, "R12 release", int'(last_rel), 1);
    end
    cmp_all("R3 singles");

    // R3: auto-increment burst.
    burst(2, 3, 8'hA1, "R3 burst");
    cmp_all("R3 burst");

    // R4: pointers out of range, and a burst running past the end.
    burst(8, 2, 8'h5A, "R4 ptr8");
    burst(255, 2, 8'h3C, "R4 ptr255");
    burst(6, 4, 8'hC7, "R4 overrun");
    cmp_all("R4 discard");

    // R5 / R6 / R7: pending accumulation, saturation, direction clear.
    reg0_seq = '{8'h64, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h05, 8'h85, 8'h80, 8'hFF, 8'h00};
    for (int k = 0; k < 10; k++) begin
      s0 = strobes;
      burst(0, 1, reg0_seq[k], "R5 reg0");
      chk(strobes - s0 == 1, "R7 strobe count", strobes - s0, 1);
      chk(int'(op_pending) == m_pend, "R5 R6 pending", int'(op_pending), m_pend);
      chk(op_dir == m_dir, "R6 dir", int'(op_dir), int'(m_dir));
    end
    for (int k = 0; k < 6; k++) burst(0, 1, 8'h7F, "R5 sat");
    chk(int'(op_pending) == 512, "R5 cap", int'(op_pending), 512);
    burst(0, 1, 8'h83, "R6 flip at cap");
    chk(int'(op_pending) == 3, "R6 flip at cap", int'(op_pending), 3);
    cmp_all("R5 final");

    // R11: repeated START to a bad address, then to the good one.
    bus_start(); send_byte(8'hE4, ack); send_byte(8'h02, ack);
    bus_start(); send_byte(8'h10, ack); chk(ack == 1'b0, "R11 restart nack", int'(ack), 0);
    send_byte(8'h55, ack); bus_stop();
    cmp_all("R11 restart bad");
    bus_start(); send_byte(8'hE4, ack); send_byte(8'h03, ack);
    bus_start(); send_byte(8'hE4, ack); chk(ack, "R11 restart ack", int'(ack), 1);
    send_byte(8'h05, ack); send_byte(8'h3C, ack); bus_stop();
    model_write(5, 8'h3C);
    cmp_all("R11 restart good");
    // R11: bytes after STOP without START.
    send_byte(8'hE4, ack); chk(ack == 1'b0, "R11 no start", int'(ack), 0);
    send_byte(8'h02, ack); send_byte(8'h66, ack); bus_stop();
    cmp_all("R11 no start");

    // R10: test presets and lock.
    do_reset(1'b1);
    cmp_all("R10 preset");
    burst(2, 1, 8'h99, "R10 locked");
    burst(6, 2, 8'h01, "R10 locked");
    burst(1, 1, 8'hAB, "R10 reg1 open");
    burst(0, 1, 8'h03, "R10 reg0 open");
    cmp_all("R10 lock");
    test_preset = 1'b0; m_lock = 1'b0;
    @(negedge clk);
    burst(2, 1, 8'h99, "R10 unlocked");
    cmp_all("R10 unlock");
    chk(sda_pull == 1'b0, "R12 idle", int'(sda_pull), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule